// File: doc/BRIEF.md
# Virtual Interrupt Pending Selector

This block looks at a small set of virtual interrupt list entries and picks the one pending entry that should be offered to the virtual processor next. It reports whether a winner exists, the winner's index, its 8-bit priority and its non-maskable (NMI) flag. It also reports whether that winner may preempt the current running priority. The decision combines the group-priority mask, the running priority and whether an NMI is already active.

Selection is combinational across all entries. The result is captured in one output register stage, so every output reflects the inputs present at the previous rising clock edge. Winners are ranked first by numerically lower priority. Among equal priorities, an NMI entry beats a non-NMI entry, and after that the lower index wins. Preemption follows the usual rule that a strictly lower masked priority may preempt. The exception is an NMI candidate at an equal masked priority, which may preempt when no NMI is currently active.

Top module: `vpend_select`

## Requirements
- R1: Each 64-bit entry carries its priority in bits 55:48, its NMI flag in bit 59, its group in bit 60 (0 = group 0, 1 = group 1) and its state in bits 63:62. Only the state value 2'b01 (pending) makes an entry a candidate, and the states 2'b00, 2'b10 and 2'b11 are never selected.
- R2: When both group enables are low, no entry is selected (sel_valid = 0).
- R3: An entry whose own group enable is low is skipped even if it is pending.
- R4: Among candidates, the one with the numerically lowest priority wins, and sel_prio reports that entry's priority.
- R5: The search starts at priority 0xFF with no NMI. A non-NMI entry at priority 0xFF is therefore never selected, while an NMI entry at 0xFF is.
- R6: At equal priority, an NMI candidate replaces a non-NMI best, whatever their indices.
- R7: Candidates tying on both priority and NMI flag resolve to the lowest index.
- R8: With nmi_feat_en low, every NMI flag is treated as 0. sel_nmi stays 0, and ties resolve by index alone.
- R9: sel_preempt is 1 when the winner's priority ANDed with prio_mask is strictly below run_prio ANDed with prio_mask.
- R10: At equal masked priority, sel_preempt is 1 only for an NMI winner while nmi_active is low. It stays 0 for a non-NMI winner, and for any winner while nmi_active is high.
- R11: All outputs are registered, with one cycle of latency. During reset, and whenever no winner exists, the outputs are sel_valid = 0, sel_idx = 0, sel_prio = 0xFF, sel_nmi = 0 and sel_preempt = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lr_flat | input | NUM_LR*64 | List entries, entry i in bits [64*i+63:64*i] |
| grp0_en | input | 1 | Virtual group 0 enable |
| grp1_en | input | 1 | Virtual group 1 enable |
| run_prio | input | 8 | Current running priority |
| prio_mask | input | 8 | Group-priority mask |
| nmi_feat_en | input | 1 | NMI feature enable |
| nmi_active | input | 1 | An NMI is currently active |
| sel_valid | output | 1 | A winner exists |
| sel_idx | output | IDX_W | Index of the winner |
| sel_prio | output | 8 | Priority of the winner |
| sel_nmi | output | 1 | NMI flag of the winner |
| sel_preempt | output | 1 | The winner may preempt |

## Verification
The assertions check on every cycle that a reported winner really was a pending entry of an enabled group and carries that entry's priority. They also check that a preempt is never reported without a winner or above the masked running priority, that a 0xFF winner is always an NMI, and that disabled enables or a disabled NMI feature hold the outputs low. The ordering rules cannot be seen from one entry alone and need the bench's directed scenarios. These rules are lowest priority first, the NMI tie-break, lowest index last, and the exact equal-priority preemption conditions.

// File: rtl/vps_pkg.sv
// Shared constants and types for the virtual pending selector.
package vps_pkg;
    localparam int LR_W       = 64;
    localparam int PRIO_W     = 8;
    localparam int PRIO_LSB   = 48;
    localparam int NMI_BIT    = 59;
    localparam int GRP_BIT    = 60;
    localparam int STATE_LSB  = 62;

    typedef enum logic [1:0] {
        ST_INV  = 2'b00,
        ST_PEND = 2'b01,
        ST_ACT  = 2'b10,
        ST_PA   = 2'b11
    } lr_state_e;

    typedef struct packed {
        logic              cand;
        logic [PRIO_W-1:0] prio;
        logic              nmi;
    } cand_t;
endpackage

// File: rtl/vps_lr_decode.sv
// Decodes one list entry into a candidate record.
// Assumes the field layout in vps_pkg; the NMI flag is forced to zero
// when the feature is disabled.
module vps_lr_decode
    import vps_pkg::*;
(
    input  logic [LR_W-1:0] lr,
    input  logic            grp0_en,
    input  logic            grp1_en,
    input  logic            nmi_feat_en,
    output cand_t           cand_o
);
    lr_state_e st;
    logic      grp_ok;

    // Extract fields and qualify the entry as a candidate.
    always_comb begin
        st            = lr_state_e'(lr[STATE_LSB +: 2]);
        grp_ok        = lr[GRP_BIT] ? grp1_en : grp0_en;
        cand_o.cand   = (st == ST_PEND) && grp_ok;
        cand_o.prio   = lr[PRIO_LSB +: PRIO_W];
        cand_o.nmi    = lr[NMI_BIT] & nmi_feat_en;
    end
endmodule

// File: rtl/vps_winner.sv
// Ordered scan over candidates: lower priority wins, an NMI wins an
// equal-priority tie against a non-NMI, otherwise the earlier index holds.
// Assumes the scan starts from priority all-ones with no NMI.
module vps_winner
    import vps_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
)(
    input  cand_t              cands [NUM_LR],
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx,
    output logic [PRIO_W-1:0]  win_prio,
    output logic               win_nmi
);
    // Linear scan keeping the running best.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '1;
        win_nmi   = 1'b0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (cands[i].cand &&
                ((cands[i].prio < win_prio) ||
                 ((cands[i].prio == win_prio) && cands[i].nmi && !win_nmi))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = cands[i].prio;
                win_nmi   = cands[i].nmi;
            end
        end
    end
endmodule

// File: rtl/vps_preempt.sv
// Decides whether the winner may preempt the running priority.
// Assumes win_nmi is already cleared when the NMI feature is off.
module vps_preempt
    import vps_pkg::*;
(
    input  logic              win_valid,
    input  logic [PRIO_W-1:0] win_prio,
    input  logic              win_nmi,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic [PRIO_W-1:0] prio_mask,
    input  logic              nmi_active,
    output logic              preempt
);
    logic [PRIO_W-1:0] m_win, m_run;

    // Masked compare with the NMI equal-priority allowance.
    always_comb begin
        m_win   = win_prio & prio_mask;
        m_run   = run_prio & prio_mask;
        preempt = win_valid &&
                  ((m_win < m_run) ||
                   ((m_win == m_run) && win_nmi && !nmi_active));
    end
endmodule

// File: rtl/vpend_select.sv
// Virtual interrupt pending selector top.
// Decodes NUM_LR list entries, selects the winner, evaluates preemption
// and registers the result. Assumes 1 <= NUM_LR <= 16.
module vpend_select
    import vps_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LR*LR_W-1:0] lr_flat,
    input  logic                   grp0_en,
    input  logic                   grp1_en,
    input  logic [PRIO_W-1:0]      run_prio,
    input  logic [PRIO_W-1:0]      prio_mask,
    input  logic                   nmi_feat_en,
    input  logic                   nmi_active,
    output logic                   sel_valid,
    output logic [IDX_W-1:0]       sel_idx,
    output logic [PRIO_W-1:0]      sel_prio,
    output logic                   sel_nmi,
    output logic                   sel_preempt
);
    cand_t              cands [NUM_LR];
    logic               w_valid, w_nmi, w_pre;
    logic [IDX_W-1:0]   w_idx;
    logic [PRIO_W-1:0]  w_prio;

    for (genvar g = 0; g < NUM_LR; g++) begin : g_dec
        vps_lr_decode u_dec (
            .lr          (lr_flat[g*LR_W +: LR_W]),
            .grp0_en     (grp0_en),
            .grp1_en     (grp1_en),
            .nmi_feat_en (nmi_feat_en),
            .cand_o      (cands[g])
        );
    end

    vps_winner #(.NUM_LR(NUM_LR)) u_win (
        .cands     (cands),
        .win_valid (w_valid),
        .win_idx   (w_idx),
        .win_prio  (w_prio),
        .win_nmi   (w_nmi)
    );

    vps_preempt u_pre (
        .win_valid  (w_valid),
        .win_prio   (w_prio),
        .win_nmi    (w_nmi),
        .run_prio   (run_prio),
        .prio_mask  (prio_mask),
        .nmi_active (nmi_active),
        .preempt    (w_pre)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid   <= 1'b0;
            sel_idx     <= '0;
            sel_prio    <= '1;
            sel_nmi     <= 1'b0;
            sel_preempt <= 1'b0;
        end else begin
            sel_valid   <= w_valid;
            sel_idx     <= w_idx;
            sel_prio    <= w_prio;
            sel_nmi     <= w_nmi;
            sel_preempt <= w_pre;
        end
    end
endmodule

// File: rtl/vpend_select_chk.sv
// Checker for vpend_select: keeps a one-cycle copy of the inputs and
// relates the registered outputs to them.
module vpend_select_chk
    import vps_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
)(
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_LR*LR_W-1:0] lr_flat,
    input logic                   grp0_en,
    input logic                   grp1_en,
    input logic [PRIO_W-1:0]      run_prio,
    input logic [PRIO_W-1:0]      prio_mask,
    input logic                   nmi_feat_en,
    input logic                   nmi_active,
    input logic                   sel_valid,
    input logic [IDX_W-1:0]       sel_idx,
    input logic [PRIO_W-1:0]      sel_prio,
    input logic                   sel_nmi,
    input logic                   sel_preempt
);
    logic [NUM_LR*LR_W-1:0] lr_q;
    logic                   g0_q, g1_q;
    logic [PRIO_W-1:0]      run_q, mask_q;
    logic [LR_W-1:0]        ent;

    // Capture the inputs that produced the current outputs.
    always_ff @(posedge clk) begin
        lr_q   <= lr_flat;
        g0_q   <= grp0_en;
        g1_q   <= grp1_en;
        run_q  <= run_prio;
        mask_q <= prio_mask;
    end

    // Entry the outputs point at.
    always_comb ent = lr_q[int'(sel_idx)*LR_W +: LR_W];

    // R1
    win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (ent[STATE_LSB +: 2] == 2'b01));
    // R2
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp0_en && !grp1_en) |=> !sel_valid);
    // R3
    win_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (ent[GRP_BIT] ? g1_q : g0_q));
    // R4
    win_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_prio == ent[PRIO_LSB +: PRIO_W]));
    // R5
    ff_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_prio == 8'hFF) |-> sel_nmi);
    // R8
    nmi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_feat_en |=> !sel_nmi);
    // R9
    pre_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_preempt |-> sel_valid);
    // R10
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_preempt |-> ((sel_prio & mask_q) <= (run_q & mask_q)));
endmodule

bind vpend_select vpend_select_chk #(.NUM_LR(NUM_LR)) u_chk (
    .clk(clk), .rst_n(rst_n), .lr_flat(lr_flat), .grp0_en(grp0_en),
    .grp1_en(grp1_en), .run_prio(run_prio), .prio_mask(prio_mask),
    .nmi_feat_en(nmi_feat_en), .nmi_active(nmi_active),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_prio(sel_prio),
    .sel_nmi(sel_nmi), .sel_preempt(sel_preempt)
);

// File: tb/sim_vpend_select.sv
// Directed bench for vpend_select with four entries.
module sim_vpend_select;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   lr [N];
    logic [N*64-1:0] lr_flat;
    logic          grp0_en, grp1_en, nmi_feat_en, nmi_active;
    logic [7:0]    run_prio, prio_mask;
    logic          sel_valid, sel_nmi, sel_preempt;
    logic [1:0]    sel_idx;
    logic [7:0]    sel_prio;
    int            total = 0;
    int            bad = 0;

    always #5 clk = ~clk;

    always_comb for (int i = 0; i < N; i++) lr_flat[i*64 +: 64] = lr[i];

    vpend_select #(.NUM_LR(N)) u0 (
        .clk(clk), .rst_n(rst_n), .lr_flat(lr_flat), .grp0_en(grp0_en),
        .grp1_en(grp1_en), .run_prio(run_prio), .prio_mask(prio_mask),
        .nmi_feat_en(nmi_feat_en), .nmi_active(nmi_active),
        .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_prio(sel_prio),
        .sel_nmi(sel_nmi), .sel_preempt(sel_preempt)
    );

    function automatic logic [63:0] mk(input logic [1:0] st, input logic grp,
                                       input logic nmi, input logic [7:0] p);
        logic [63:0] v = '0;
        v[63:62] = st;
        v[60]    = grp;
        v[59]    = nmi;
        v[55:48] = p;
        return v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply at negedge, let one posedge register it, sample at next negedge.
    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all;
        for (int i = 0; i < N; i++) lr[i] = '0;
        grp0_en = 1; grp1_en = 1; nmi_feat_en = 1; nmi_active = 0;
        run_prio = 8'hFF; prio_mask = 8'hFF;
    endtask

    task automatic expect_win(input string tag, input int v, input int idx,
                              input int p, input int n);
        chk({tag, " valid"}, sel_valid, v);
        chk({tag, " idx"},   sel_idx, idx);
        chk({tag, " prio"},  sel_prio, p);
        chk({tag, " nmi"},   sel_nmi, n);
    endtask

    task automatic t_reset;
        clear_all();
        lr[0] = mk(2'b01, 0, 0, 8'h10);
        @(negedge clk);
        expect_win("R11 reset", 0, 0, 8'hFF, 0);
        chk("R11 reset preempt", sel_preempt, 0);
        rst_n = 1;
        @(negedge clk);
        expect_win("R11 latency", 1, 0, 8'h10, 0);
    endtask

    task automatic t_state;
        clear_all();
        lr[0] = mk(2'b00, 0, 0, 8'h01);
        lr[1] = mk(2'b10, 0, 0, 8'h02);
        lr[2] = mk(2'b11, 0, 0, 8'h03);
        step();
        expect_win("R1 nonpending", 0, 0, 8'hFF, 0);
        lr[3] = mk(2'b01, 0, 0, 8'h40);
        step();
        expect_win("R1 pending", 1, 3, 8'h40, 0);
    endtask

    task automatic t_enables;
        clear_all();
        lr[0] = mk(2'b01, 0, 0, 8'h20);
        lr[1] = mk(2'b01, 1, 0, 8'h30);
        grp0_en = 0; grp1_en = 0;
        step();
        expect_win("R2 both off", 0, 0, 8'hFF, 0);
        grp1_en = 1;
        step();
        expect_win("R3 grp0 off", 1, 1, 8'h30, 0);
        grp0_en = 1; grp1_en = 0;
        lr[0] = mk(2'b01, 1, 0, 8'h20);
        lr[1] = mk(2'b01, 0, 0, 8'h50);
        step();
        expect_win("R3 grp1 off", 1, 1, 8'h50, 0);
    endtask

    task automatic t_prio;
        clear_all();
        lr[0] = mk(2'b01, 0, 0, 8'h80);
        lr[1] = mk(2'b01, 1, 0, 8'h30);
        lr[2] = mk(2'b01, 0, 0, 8'h90);
        lr[3] = mk(2'b01, 1, 0, 8'h31);
        step();
        expect_win("R4 lowest", 1, 1, 8'h30, 0);
    endtask

    task automatic t_ff;
        clear_all();
        lr[0] = mk(2'b01, 0, 0, 8'hFF);
        step();
        expect_win("R5 ff plain", 0, 0, 8'hFF, 0);
        lr[2] = mk(2'b01, 0, 1, 8'hFF);
        step();
        expect_win("R5 ff nmi", 1, 2, 8'hFF, 1);
    endtask

    task automatic t_ties;
        clear_all();
        lr[0] = mk(2'b01, 0, 0, 8'h40);
        lr[1] = mk(2'b01, 0, 0, 8'h40);
        lr[3] = mk(2'b01, 1, 1, 8'h40);
        step();
        expect_win("R6 nmi tie", 1, 3, 8'h40, 1);
        lr[2] = mk(2'b01, 0, 1, 8'h40);
        step();
        expect_win("R7 nmi index", 1, 2, 8'h40, 1);
        lr[2] = '0; lr[3] = '0;
        step();
        expect_win("R7 plain index", 1, 0, 8'h40, 0);
    endtask

    task automatic t_feat;
        clear_all();
        nmi_feat_en = 0;
        lr[1] = mk(2'b01, 0, 0, 8'h40);
        lr[2] = mk(2'b01, 0, 1, 8'h40);
        lr[3] = mk(2'b01, 0, 1, 8'hFF);
        step();
        expect_win("R8 feat off", 1, 1, 8'h40, 0);
    endtask

    task automatic t_preempt;
        clear_all();
        run_prio = 8'h80; prio_mask = 8'hF8;
        lr[0] = mk(2'b01, 0, 0, 8'h40);
        step();
        chk("R9 lower", sel_preempt, 1);
        lr[0] = mk(2'b01, 0, 0, 8'h90);
        step();
        chk("R9 higher", sel_preempt, 0);
        lr[0] = mk(2'b01, 0, 0, 8'h84);
        step();
        chk("R10 equal plain", sel_preempt, 0);
        lr[0] = mk(2'b01, 1, 1, 8'h84);
        step();
        chk("R10 equal nmi", sel_preempt, 1);
        nmi_active = 1;
        step();
        chk("R10 nmi active", sel_preempt, 0);
        nmi_active = 0; nmi_feat_en = 0;
        step();
        chk("R10 feat off", sel_preempt, 0);
        lr[0] = '0; nmi_feat_en = 1;
        step();
        chk("R11 idle preempt", sel_preempt, 0);
        expect_win("R11 idle", 0, 0, 8'hFF, 0);
    endtask

    initial begin
        t_reset();
        t_state();
        t_enables();
        t_prio();
        t_ff();
        t_ties();
        t_feat();
        t_preempt();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule